// File: doc/BRIEF.md
# Configurable Serial Converter Data Port

This block is the serial slave side of a 10-bit converter. A host lowers the select line, clocks a frame on SCLK, and on every frame the port does two things at once. It collects an 8-bit configuration word from DIN, and it returns the most recent conversion result on DOUT. The host picks the length of the returned frame (8, 10, 12 or 16 SCLK cycles) inside the configuration word of that same frame. It also picks the bit order, which applies to the frame after the current one.

The port runs on a fast system clock. SCLK, select and DIN are brought into that clock domain by a short sampling chain, and their edges are detected there. The select input reaches the port already deglitched. A conversion-busy input holds the output off while the converter works. When busy drops with select still low, the port snapshots the result and presents its first bit. DOUT is delivered together with an output-enable; the tri-state buffer is outside the block.

Top module: `sadc_port`

## Requirements
- R1: After reset the output enable is low and the stored output order is MSB-first.
- R2: The configuration word is 8 bits wide and is sampled from DIN on SCLK rising edges. The first bit received lands in word bit 7 and the eighth in word bit 0. DIN values on any later rising edges of the frame are ignored.
- R3: Word bit 2 (the sixth bit received) selects the output order: 1 gives MSB-first, 0 gives LSB-first.
- R4: A received order bit is stored only when its frame completes, and it governs the next frame. A frame that is aborted before completion leaves the stored order unchanged.
- R5: Word bits 1:0 (the seventh and eighth bits received) set the length of the current frame: 00 gives 8, 01 gives 10, 10 gives 12 and 11 gives 16 SCLK falling edges. The frame completes on the falling edge whose count equals the length.
- R6: In MSB-first order the output bit at position k is result bit 9-k. In LSB-first order it is result bit k. Positions 10 and above carry 0, so an 8-bit frame carries only the first eight bits of the chosen order.
- R7: Within a frame, DOUT moves to the next bit only on SCLK falling edges. Once a frame completes, DOUT is held at 0 and further SCLK edges are ignored until select goes high.
- R8: While select is high the output enable is low, and SCLK edges have no effect on the port.
- R9: While select is low and the busy input is high, the output enable stays low. When busy goes low, the output enable rises and DOUT presents the bit at position 0.
- R10: The result is captured when the output becomes enabled. Changes on the result input after that point do not alter the frame in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| sel_n | input | 1 | Deglitched active-low select |
| din | input | 1 | Serial configuration data from the host |
| conv_busy | input | 1 | High while a conversion is in progress |
| result | input | 10 | Latest conversion result |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for the external tri-state driver on DOUT |

## Verification
The bench goes after these corner cases:
- Order changes from one frame to the next. A design that applied the order bit at once would corrupt the tail of the current frame, and the head of the next frame would then disagree with the model.
- Aborted frames. A design that stored the order too early would flip the order after a frame cut short.
- The 12- and 16-bit lengths. Wrong padding would show result bits or stale data where zeros belong.
- Extra SCLK pulses after completion and while deselected. A port that kept shifting would produce a non-zero DOUT or a shifted configuration word.
- The busy hold-off. A design that enabled early would drive DOUT during a conversion.
- A result that changes mid-frame. A port without a snapshot would mix old and new data.

// File: rtl/sadc_port_pkg.sv
package sadc_port_pkg;

    localparam int LEN_W = 5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2
    } port_state_e;

    // Frame length in SCLK cycles for a two-bit length code.
    function automatic logic [LEN_W-1:0] len_decode(input logic [1:0] code);
        case (code)
            2'b00:   return LEN_W'(8);
            2'b01:   return LEN_W'(10);
            2'b10:   return LEN_W'(12);
            default: return LEN_W'(16);
        endcase
    endfunction

endpackage

// File: rtl/sadc_port_sync.sv
module sadc_port_sync #(
    parameter int W = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                assign stg_d[s] = async_i;
            end else begin : g_next
                assign stg_d[s] = stg_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= RST_VAL;
                else        stg_q[s] <= stg_d[s];
            end
        end
    endgenerate

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/sadc_port_cfg.sv
module sadc_port_cfg
    import sadc_port_pkg::*;
#(
    parameter int WORD_W    = 8,
    parameter int ORDER_POS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift_en,
    input  logic             din,
    output logic             cfg_valid,
    output logic             cfg_msb_first,
    output logic [LEN_W-1:0] cfg_len
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [CNT_W-1:0]  cnt;
    } cfg_regs_t;

    cfg_regs_t q, d;

    always_comb begin
        d = q;
        if (clear) begin
            d.cnt = '0;
        end else if (shift_en && (q.cnt < CNT_W'(WORD_W))) begin
            d.word = {q.word[WORD_W-2:0], din};
            d.cnt  = q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cfg_valid     = (q.cnt == CNT_W'(WORD_W));
    assign cfg_msb_first = q.word[ORDER_POS];
    assign cfg_len       = len_decode(q.word[1:0]);

    // R2: the bit counter never passes the word width
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(WORD_W));

    // R2: once the word is complete, later shifts leave it untouched
    p_word_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && !clear) |=> $stable(q.word));
endmodule

// File: rtl/sadc_port_mux.sv
module sadc_port_mux
    import sadc_port_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic [RES_W-1:0] res,
    input  logic             msb_first,
    input  logic [LEN_W-1:0] idx,
    output logic             bit_o
);
    always_comb begin
        bit_o = 1'b0;
        for (int k = 0; k < RES_W; k++) begin
            if (int'(idx) == k) begin
                bit_o = msb_first ? res[RES_W-1-k] : res[k];
            end
        end
    end
endmodule

// File: rtl/sadc_port.sv
module sadc_port
    import sadc_port_pkg::*;
#(
    parameter int RES_W       = 10,
    parameter int SYNC_STAGES = 2,
    parameter int MAX_LEN     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             sel_n,
    input  logic             din,
    input  logic             conv_busy,
    input  logic [RES_W-1:0] result,
    output logic             dout,
    output logic             dout_oe
);
    typedef struct packed {
        port_state_e      st;
        logic [LEN_W-1:0] idx;
        logic [RES_W-1:0] res;
        logic             dout;
        logic             oe;
        logic             msb_first;
        logic             sclk_prev;
    } port_regs_t;

    port_regs_t q, d;

    logic [2:0]       sync_vec;
    logic             sclk_s, sel_n_s, din_s;
    logic             rise, fall;
    logic             cfg_valid, cfg_msb_first;
    logic [LEN_W-1:0] cfg_len;
    logic [LEN_W-1:0] mux_idx;
    logic [RES_W-1:0] mux_res;
    logic             mux_bit;
    logic             frame_end;

    sadc_port_sync #(
        .W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)
    ) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({din, sel_n, sclk}),
        .sync_o(sync_vec)
    );

    assign sclk_s  = sync_vec[0];
    assign sel_n_s = sync_vec[1];
    assign din_s   = sync_vec[2];

    assign rise = sclk_s & ~q.sclk_prev;
    assign fall = ~sclk_s & q.sclk_prev;

    sadc_port_cfg #(.WORD_W(8), .ORDER_POS(2)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .clear(q.st != ST_SHIFT),
        .shift_en(rise && (q.st == ST_SHIFT) && !sel_n_s),
        .din(din_s),
        .cfg_valid(cfg_valid),
        .cfg_msb_first(cfg_msb_first),
        .cfg_len(cfg_len)
    );

    assign mux_idx = (q.st == ST_IDLE) ? '0 : q.idx + LEN_W'(1);
    assign mux_res = (q.st == ST_IDLE) ? result : q.res;

    sadc_port_mux #(.RES_W(RES_W)) u_mux (
        .res(mux_res), .msb_first(q.msb_first),
        .idx(mux_idx), .bit_o(mux_bit)
    );

    assign frame_end = cfg_valid && (q.idx + LEN_W'(1) == cfg_len);

    always_comb begin
        d = q;
        d.sclk_prev = sclk_s;
        case (q.st)
            ST_IDLE: begin
                d.oe   = 1'b0;
                d.dout = 1'b0;
                if (!sel_n_s && !conv_busy) begin
                    d.st   = ST_SHIFT;
                    d.res  = result;
                    d.idx  = '0;
                    d.oe   = 1'b1;
                    d.dout = mux_bit;
                end
            end
            ST_SHIFT: begin
                if (sel_n_s) begin
                    d.st   = ST_IDLE;
                    d.oe   = 1'b0;
                    d.dout = 1'b0;
                end else if (fall) begin
                    if (frame_end) begin
                        d.st        = ST_DONE;
                        d.dout      = 1'b0;
                        d.msb_first = cfg_msb_first;
                    end else if (q.idx < LEN_W'(MAX_LEN - 1)) begin
                        d.idx  = q.idx + LEN_W'(1);
                        d.dout = mux_bit;
                    end
                end
            end
            ST_DONE: begin
                d.dout = 1'b0;
                if (sel_n_s) begin
                    d.st = ST_IDLE;
                    d.oe = 1'b0;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.st        <= ST_IDLE;
            q.msb_first <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign dout    = q.dout;
    assign dout_oe = q.oe;

    // R8: a high select turns the output off on the next cycle
    p_off_when_deselected_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n_s |=> !dout_oe);

    // R9: no enable while a conversion runs from idle
    p_busy_holds_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && conv_busy) |=> !dout_oe);

    // R4: the stored order only moves when a frame completes
    p_order_on_completion_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.msb_first) |-> (q.st == ST_DONE && $past(q.st) == ST_SHIFT));

    // R7: a completed frame drives zero
    p_done_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DONE) |-> !dout);

    // R7: within a frame DOUT moves only after a falling SCLK
    p_dout_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SHIFT && $past(q.st) == ST_SHIFT && !$stable(dout)) |-> $past(fall));

    // R5: the position index stays inside the longest frame
    p_idx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SHIFT) |-> (q.idx < LEN_W'(MAX_LEN)));
endmodule

// File: tb/sadc_port_test.sv
module sadc_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       sel_n = 1'b1;
    logic       din = 1'b0;
    logic       conv_busy = 1'b0;
    logic [9:0] result = '0;
    logic       dout, dout_oe;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    bit  model_msb = 1'b1;
    int  seed_sink;

    always #2 clk = ~clk;

    sadc_port uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sel_n(sel_n), .din(din),
        .conv_busy(conv_busy), .result(result), .dout(dout), .dout_oe(dout_oe)
    );

    function automatic int len_of(input logic [1:0] code);
        case (code)
            2'b00:   return 8;
            2'b01:   return 10;
            2'b10:   return 12;
            default: return 16;
        endcase
    endfunction

    function automatic logic exp_bit(input bit msb, input logic [9:0] r, input int k);
        if (k >= 10) return 1'b0;
        return msb ? r[9-k] : r[k];
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // abort_after < 0 runs the full frame; otherwise select rises after that many bits
    task automatic run_frame(input logic [7:0] word, input logic [9:0] res, input int abort_after);
        int  len;
        bit  ord;
        bit  alive;
        len   = len_of(word[1:0]);
        ord   = model_msb;
        alive = 1'b1;
        result = res;
        sel_n  = 1'b0;
        wait_clk(12);
        chk("R9 enable", dout_oe, 1'b1);
        chk("R6 first bit", dout, exp_bit(ord, res, 0));
        result = res ^ 10'($urandom);  // R10: frame must keep the snapshot
        for (int i = 0; i < len; i++) begin
            if (alive && abort_after == i) alive = 1'b0;
            if (alive) begin
                din = (i < 8) ? word[7-i] : 1'($urandom);
                wait_clk(8);
                sclk = 1'b1;
                wait_clk(4);
                chk("R7 holds across rise", dout, exp_bit(ord, res, i));
                wait_clk(4);
                sclk = 1'b0;
                wait_clk(8);
                if (i + 1 < len) chk("R6 R10 data bit", dout, exp_bit(ord, res, i + 1));
                else             chk("R5 frame end low", dout, 1'b0);
            end
        end
        if (alive) begin
            din = 1'b1;
            sclk = 1'b1; wait_clk(8);
            sclk = 1'b0; wait_clk(8);
            chk("R7 ignored after end", dout, 1'b0);
            model_msb = word[2];
        end
        sel_n = 1'b1;
        wait_clk(8);
        chk("R8 off when deselected", dout_oe, 1'b0);
        wait_clk(4);
    endtask

    initial begin
        seed_sink = $urandom(32'h5EED_0283);
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);
        chk("R1 reset enable", dout_oe, 1'b0);

        // R1 default order MSB-first, R3 select LSB for next frame, R5 16-bit length
        run_frame(8'b0000_0011, 10'b10_0000_0001, -1);
        // R4: this frame is LSB-first, asks MSB-first with 12-bit length
        run_frame(8'b0000_0110, 10'b11_0101_0010, -1);
        // R4: aborted frame asks LSB but must leave MSB stored
        run_frame(8'b1111_1000, 10'h2A5, 3);
        chk("R4 order kept after abort", 1'(model_msb), 1'b1);
        // R2: all-ones in the bits after the word on a 16-bit frame, order bit 0
        run_frame(8'b0000_0011, 10'h3FF, -1);
        // each length in LSB then MSB order
        for (int c = 0; c < 4; c++) begin
            run_frame({5'b00000, 1'b1, 2'(c)}, 10'($urandom), -1);
            run_frame({5'b11111, 1'b0, 2'(c)}, 10'($urandom), -1);
        end

        // R8: SCLK activity while deselected is ignored
        for (int k = 0; k < 12; k++) begin
            din = 1'($urandom);
            sclk = 1'b1; wait_clk(6);
            chk("R8 no enable on sclk", dout_oe, 1'b0);
            sclk = 1'b0; wait_clk(6);
        end
        run_frame(8'b1010_0101, 10'h155, -1);

        // R9: busy holds the output off, release presents bit 0
        conv_busy = 1'b1;
        sel_n = 1'b0;
        wait_clk(20);
        chk("R9 busy holds off", dout_oe, 1'b0);
        result = 10'h201;
        conv_busy = 1'b0;
        wait_clk(6);
        chk("R9 enable after busy", dout_oe, 1'b1);
        chk("R9 first bit after busy", dout, exp_bit(model_msb, 10'h201, 0));
        sel_n = 1'b1;
        wait_clk(10);

        // constrained random frames
        for (int f = 0; f < 60; f++) begin
            logic [7:0] w;
            int ab;
            w  = 8'($urandom);
            ab = (($urandom % 8) == 0) ? int'($urandom % 8) : -1;
            run_frame(w, 10'($urandom), ab);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule